// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block gathers the level-sensitive interrupt requests of PCI devices into 32 interrupt lines. The devices sit either on the primary bus or behind one of the secondary bridges. Each request source presents four things:

- a level;
- a flag saying whether it sits behind a secondary bridge;
- its device/function number;
- its pin number, where 0 to 3 stand for INTA to INTD.

The block turns every source into a line index. All sources that land on the same line are OR-ed together.

Each group of four consecutive lines has one enable. That enable is bit 31 of a 32-bit map register, supplied by a neighbouring register block on a flat bus. While the enable is set, the four lines follow their requests. While it is clear, they are forced low. The gated result is registered once, and the 32 outputs feed an interrupt controller one to one.

Top module: `pci_irq_router`

## Requirements
- R1: A primary-bus source (bridge flag 0) maps to line pin + 16 when bit 0 of its device/function number is 1, and to line pin when that bit is 0. Pin values 0..3 stand for INTA..INTD.
- R2: A source behind a bridge (bridge flag 1) maps to line 4*devfn[4:3] + pin. Device/function bits [2:0] and [7:5] have no effect on its line.
- R3: A line is high when any enabled source mapped to it has its level high. A shared line stays high while at least one of its sources remains active.
- R4: Line n is gated by bit 31 of map register n/4, where map register k occupies bits [32k+31:32k] of the map bus. When that bit is 0, line n is low one clock edge later, whatever its requests are.
- R5: Map register bits other than bit 31 have no effect on any line. This includes the power-up pattern (0x1F << 6) | (k << 2).
- R6: Outputs are registered. A change on any input appears on the outputs at the next rising clock edge. Setting an enable bit again restores the live request level without the request having to toggle.
- R7: While the active-low reset is asserted, all 32 lines are low.
- R8: A line to which no active source maps stays low. In particular, bridge-only traffic never drives lines 16..31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | NSRC | Request level of each source |
| src_on_bridge | input | NSRC | 1 = source sits behind a secondary bridge |
| src_devfn | input | NSRC*8 | Device/function number of each source, source s at bits [8s+7:8s] |
| src_pin | input | NSRC*2 | Interrupt pin of each source (0..3 = INTA..INTD), source s at bits [2s+1:2s] |
| map_regs | input | 256 | Eight map registers, register k at bits [32k+31:32k] |
| irq_out | output | 32 | Gated interrupt lines |

## Verification
The assertions take the inputs to be synchronous to the clock and stable around each rising edge. Under that assumption, whatever is sampled at one edge is fully reflected one edge later. They also take the pin field to be 2 bits wide, so every computed index is a real line and no out-of-range case has to be considered.

The bench changes inputs only on falling edges and draws pins from 0..3. It mixes random device numbers, bridge flags, levels and enable patterns with directed cases: shared lines, filler bits in the map registers, and enables toggled while requests are held.

// File: rtl/pci_irq_router.sv
module pci_irq_router #(
  parameter int NSRC    = 8,
  parameter int DEVFN_W = 8,
  parameter int PIN_W   = 2,
  parameter int NLINE   = 32,
  parameter int MAP_W   = 32,
  parameter int EN_BIT  = 31,
  parameter int FN1_OFS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          src_level,
  input  logic [NSRC-1:0]          src_on_bridge,
  input  logic [NSRC*DEVFN_W-1:0]  src_devfn,
  input  logic [NSRC*PIN_W-1:0]    src_pin,
  input  logic [(NLINE/4)*MAP_W-1:0] map_regs,
  output logic [NLINE-1:0]         irq_out
);
  localparam int NMAP  = NLINE / 4;
  localparam int LW    = $clog2(NLINE);
  localparam int IDX_W = LW + 1;

  logic [NLINE-1:0] req;
  logic [NLINE-1:0] line_en;

  function automatic logic [IDX_W-1:0] line_of(input logic br,
                                               input logic [DEVFN_W-1:0] df,
                                               input logic [PIN_W-1:0] pin);
    if (br)
      return IDX_W'({df[4:3], 2'b00}) + IDX_W'(pin);
    else
      return (df[0] ? IDX_W'(FN1_OFS) : IDX_W'(0)) + IDX_W'(pin);
  endfunction

  always_comb begin
    logic [IDX_W-1:0] idx;
    req = '0;
    for (int s = 0; s < NSRC; s++) begin
      idx = line_of(src_on_bridge[s], src_devfn[s*DEVFN_W +: DEVFN_W],
                    src_pin[s*PIN_W +: PIN_W]);
      if (src_level[s] && (int'(idx) < NLINE))
        req[idx[LW-1:0]] = 1'b1;
    end
  end

  for (genvar n = 0; n < NLINE; n++) begin : g_en
    assign line_en[n] = map_regs[(n / 4) * MAP_W + EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_out <= '0;
    else        irq_out <= req & line_en;

  logic unused_bits;
  assign unused_bits = ^{map_regs, src_devfn, NMAP};
endmodule

// File: rtl/pci_irq_router_chk.sv
module pci_irq_router_chk #(
  parameter int NSRC    = 8,
  parameter int DEVFN_W = 8,
  parameter int PIN_W   = 2,
  parameter int NLINE   = 32,
  parameter int MAP_W   = 32,
  parameter int EN_BIT  = 31,
  parameter int FN1_OFS = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NSRC-1:0]          src_level,
  input logic [NSRC-1:0]          src_on_bridge,
  input logic [NSRC*DEVFN_W-1:0]  src_devfn,
  input logic [NSRC*PIN_W-1:0]    src_pin,
  input logic [(NLINE/4)*MAP_W-1:0] map_regs,
  input logic [NLINE-1:0]         irq_out
);
  a_r7_reset_low: assert property (@(posedge clk)
    !rst_n |=> (irq_out == '0));

  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (src_level == '0) |=> (irq_out == '0));

  a_r8_bridge_lower_half: assert property (@(posedge clk) disable iff (!rst_n)
    (&src_on_bridge) |=> (irq_out[NLINE-1:NLINE/2] == '0));

  for (genvar n = 0; n < NLINE; n++) begin : g_gate
    a_r4_gated_low: assert property (@(posedge clk) disable iff (!rst_n)
      !map_regs[(n / 4) * MAP_W + EN_BIT] |=> !irq_out[n]);
  end

  logic unused_chk;
  assign unused_chk = ^{src_devfn, src_pin, FN1_OFS};
endmodule

bind pci_irq_router pci_irq_router_chk #(
  .NSRC(NSRC), .DEVFN_W(DEVFN_W), .PIN_W(PIN_W), .NLINE(NLINE),
  .MAP_W(MAP_W), .EN_BIT(EN_BIT), .FN1_OFS(FN1_OFS)
) i_chk (
  .clk(clk), .rst_n(rst_n), .src_level(src_level),
  .src_on_bridge(src_on_bridge), .src_devfn(src_devfn),
  .src_pin(src_pin), .map_regs(map_regs), .irq_out(irq_out)
);

// File: tb/test_pci_irq_router.sv
module test_pci_irq_router;
  localparam int NSRC = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NSRC-1:0]   lvl = '0;
  logic [NSRC-1:0]   br = '0;
  logic [NSRC*8-1:0] df = '0;
  logic [NSRC*2-1:0] pn = '0;
  logic [255:0]      maps = '0;
  logic [31:0]       irq;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pci_irq_router #(.NSRC(NSRC)) i_pci_irq_router (
    .clk(clk), .rst_n(rst_n), .src_level(lvl), .src_on_bridge(br),
    .src_devfn(df), .src_pin(pn), .map_regs(maps), .irq_out(irq)
  );

  function automatic logic [31:0] model();
    logic [31:0] r = '0;
    for (int n = 0; n < 32; n++) begin
      bit hit = 0;
      for (int s = 0; s < NSRC; s++) begin
        int tgt;
        if (br[s]) tgt = 4 * int'(df[s*8+3 +: 2]) + int'(pn[s*2 +: 2]);
        else       tgt = (df[s*8] ? 16 : 0) + int'(pn[s*2 +: 2]);
        if (lvl[s] && tgt == n) hit = 1;
      end
      r[n] = hit && maps[(n / 4) * 32 + 31];
    end
    return r;
  endfunction

  function automatic logic [255:0] init_maps(input logic [7:0] en);
    logic [255:0] m;
    for (int k = 0; k < 8; k++)
      m[k*32 +: 32] = {en[k], 31'((32'h1F << 6) | (k << 2))};
    return m;
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s: irq_out=%h expected=%h", tag, irq, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_src(input int s, input logic l, input logic b,
                         input logic [7:0] d, input logic [1:0] p);
    lvl[s] = l; br[s] = b; df[s*8 +: 8] = d; pn[s*2 +: 2] = p;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: expired, expected=run complete");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R7: requests and enables active while reset held
    lvl = '1; maps = init_maps(8'hFF);
    cycle(); cycle();
    check("R7", 32'h0);
    @(negedge clk) rst_n = 1'b1;
    lvl = '0;
    cycle();
    check("R7", 32'h0);

    // R1: primary bus, function bit set, INTD -> line 19
    set_src(0, 1'b1, 1'b0, 8'h01, 2'd3);
    cycle();
    check("R1", 32'h0008_0000);
    // R1: function bit clear, INTB -> line 1
    set_src(0, 1'b1, 1'b0, 8'hFE, 2'd1);
    cycle();
    check("R1", 32'h0000_0002);

    // R2: bridge, slot bits 3, other bits set, INTC -> line 14
    set_src(0, 1'b1, 1'b1, 8'hFF, 2'd2);
    cycle();
    check("R2", 32'h0000_4000);
    set_src(0, 1'b1, 1'b1, 8'hE7, 2'd0);
    cycle();
    check("R2", 32'h0000_0000 | (32'h1 << 0));

    // R3: two sources on line 5, drop one
    set_src(0, 1'b1, 1'b1, 8'h08, 2'd1);
    set_src(1, 1'b1, 1'b0, 8'h00, 2'd0);
    set_src(2, 1'b1, 1'b1, 8'h08, 2'd1);
    cycle();
    check("R3", 32'h0000_0021);
    lvl[0] = 1'b0;
    cycle();
    check("R3", 32'h0000_0021);
    lvl[2] = 1'b0;
    cycle();
    check("R3", 32'h0000_0001);

    // R4: clear enable of group 0 with line 0 requested
    maps[31] = 1'b0;
    cycle();
    check("R4", 32'h0);
    // R6: re-enable restores without toggling request
    maps[31] = 1'b1;
    cycle();
    check("R6", 32'h0000_0001);

    // R5: all filler bits set, enable clear -> nothing
    lvl = '1;
    for (int k = 0; k < 8; k++) maps[k*32 +: 32] = 32'h7FFF_FFFF;
    cycle();
    check("R5", 32'h0);
    maps = init_maps(8'hFF);
    for (int k = 0; k < 8; k++) maps[k*32 +: 31] = '0;
    cycle();
    check("R5", model());

    // R8: bridge-only traffic with all enables
    br = '1;
    for (int i = 0; i < 60; i++) begin
      df = {$urandom, $urandom}; pn = 16'($urandom);
      lvl = 8'($urandom);
      cycle();
      check("R8", model());
      if (irq[31:16] !== 16'h0) check("R8", {16'h0, irq[15:0]});
    end

    // random mix: R1 R2 R3 R4 R6
    for (int i = 0; i < 500; i++) begin
      lvl = 8'($urandom) & 8'($urandom);
      br  = 8'($urandom);
      df  = {$urandom, $urandom};
      pn  = 16'($urandom);
      for (int k = 0; k < 8; k++)
        maps[k*32 +: 32] = {($urandom % 4) != 0, 31'($urandom)};
      cycle();
      check("R1,R2,R3,R4,R6", model());
    end

    // R4/R6 toggle enables only, requests held
    for (int i = 0; i < 40; i++) begin
      for (int k = 0; k < 8; k++) maps[k*32+31] = 1'($urandom);
      cycle();
      check("R4,R6", model());
    end

    finished = 1'b1;
    finish_run();
  end
endmodule